// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers a bank of level-sensitive device interrupt lines into one shared pending register. Every CPU owns an enable mask the width of that register. The block keeps, for each CPU, a masked status: the pending bits that the CPU's mask lets through. Each CPU has one level-sensitive device interrupt output. That output is high while any bit of the CPU's masked status is set.

Software reaches the block through a plain register port that moves one full register per access. Registers are spaced 64 bytes apart, so the register index is the byte offset shifted right by six. One index bit chooses between the mask bank and the status bank, and the bits below it choose the CPU. A mask write replaces the whole mask. Status registers can be read but not written. Interrupt outputs follow individual bits as they are set and cleared: a new pending line, a mask bit that is newly enabled, a mask bit that is removed, or a line that drops. Nothing is latched as an event.

Top module: `irq_router`

## Requirements
- R1: While reset is active, and after it, all masks, the pending register and every masked status read as zero, every CPU interrupt output is low and the read data is zero.
- R2: Pending bit i equals device line i as sampled at the previous rising clock edge. It is set when the line rises and cleared when the line falls.
- R3: The masked status of CPU n equals the mask of CPU n ANDed with the pending register. It is updated in the same cycle as any change to either operand, for every CPU at once.
- R4: The interrupt output of CPU n is the OR of its masked status, registered once. When a mask write enables a bit that is already pending, the output rises on the clock edge after the write takes effect.
- R5: When a mask write removes a bit that was contributing to the masked status, that bit stops contributing. The same happens when the device line falls. The output drops only when no enabled pending bit remains, and stays high while another one does.
- R6: The register index is reg_addr_i shifted right by six, and address bits 5:0 are ignored. Index bit 2 (address bit 8) selects the bank: 0 for masks and 1 for status. Index bits 1:0 (address bits 7:6) give the CPU number. A write to the mask bank replaces that CPU's whole mask with reg_wdata_i.
- R7: Writes to the status bank (address bit 8 set) are ignored. No mask changes, and the status still follows mask AND pending.
- R8: Read data is registered. reg_rdata_o shows the selected register on the clock edge after reg_rd_i and holds that value until the next read. A read and a write of the same mask in one cycle return the mask as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_irq_i | input | N_LINES (64) | Level device interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (9) | Byte offset of the register |
| reg_wdata_i | input | N_LINES (64) | Write data |
| reg_rdata_o | output | N_LINES (64) | Registered read data |
| cpu_irq_o | output | N_CPUS (4) | Device interrupt output, one per CPU |

## Verification
The bench walks a single pending bit across all 64 lines while four masks of different shape are loaded. A router that shares one mask between CPUs, or mixes up bit positions, shows the wrong status on some CPU for some bit. The bench enables an already pending bit and then removes it again. A design that recomputed status only when a line changed would miss both edges. It also removes one of two contributing bits, where a design that cleared the output on any mask change would drop it too early. Status-bank writes, stray low address bits and a read that collides with a write are aimed at decoders that corrupt a mask or return the new value a cycle early.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    // byte spacing of registers is 2**REG_SPAN_LG2
    localparam int REG_SPAN_LG2 = 6;

    typedef enum logic {
        BANK_MASK   = 1'b0,
        BANK_STATUS = 1'b1
    } bank_e;
endpackage

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg #(
    parameter int N_LINES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] pend_o
);
    logic [N_LINES-1:0] pend_q;

    // each bit simply tracks its line level, set and clear alike
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= lines_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_cpu_slice.sv
`timescale 1ns/1ps
module irq_cpu_slice #(
    parameter int N_LINES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we_i,
    input  logic [N_LINES-1:0] wdata_i,
    input  logic [N_LINES-1:0] pend_i,
    output logic [N_LINES-1:0] mask_o,
    output logic [N_LINES-1:0] status_o,
    output logic               irq_o
);
    logic [N_LINES-1:0] mask_q;
    logic               irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= wdata_i;
    end

    // status follows both operands without any extra storage
    assign status_o = mask_q & pend_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_o;
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irq_rd_mux.sv
`timescale 1ns/1ps
module irq_rd_mux
    import irq_route_pkg::*;
#(
    parameter int N_CPUS  = 4,
    parameter int N_LINES = 64,
    parameter int CPU_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en_i,
    input  bank_e                           bank_i,
    input  logic [CPU_W-1:0]                cpu_sel_i,
    input  logic [N_CPUS-1:0][N_LINES-1:0]  mask_i,
    input  logic [N_CPUS-1:0][N_LINES-1:0]  status_i,
    output logic [N_LINES-1:0]              rdata_o
);
    logic [N_LINES-1:0] sel_val;
    logic [N_LINES-1:0] rdata_q;

    always_comb begin
        sel_val = '0;
        if (int'(cpu_sel_i) < N_CPUS) begin
            unique case (bank_i)
                BANK_MASK:   sel_val = mask_i[cpu_sel_i];
                BANK_STATUS: sel_val = status_i[cpu_sel_i];
                default:     sel_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= sel_val;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irq_route_pkg::*;
#(
    parameter int N_CPUS  = 4,
    parameter int N_LINES = 64,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int ADDR_W = REG_SPAN_LG2 + CPU_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] dev_irq_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [N_LINES-1:0] reg_wdata_i,
    output logic [N_LINES-1:0] reg_rdata_o,
    output logic [N_CPUS-1:0]  cpu_irq_o
);
    logic [N_LINES-1:0]              pend_q;
    logic [N_CPUS-1:0][N_LINES-1:0]  mask_q;
    logic [N_CPUS-1:0][N_LINES-1:0]  status_w;
    logic [N_CPUS-1:0]               mask_we;
    logic [CPU_W-1:0]                cpu_sel;
    bank_e                           bank;
    logic                            addr_low_unused;

    // index = offset >> 6; top index bit is the bank, the rest the CPU
    assign cpu_sel         = reg_addr_i[REG_SPAN_LG2 +: CPU_W];
    assign bank            = bank_e'(reg_addr_i[ADDR_W-1]);
    assign addr_low_unused = ^reg_addr_i[REG_SPAN_LG2-1:0];

    irq_pend_reg #(.N_LINES(N_LINES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (dev_irq_i),
        .pend_o  (pend_q)
    );

    for (genvar n = 0; n < N_CPUS; n++) begin : g_cpu
        assign mask_we[n] = reg_wr_i && (bank == BANK_MASK)
                            && (cpu_sel == CPU_W'(n));

        irq_cpu_slice #(.N_LINES(N_LINES)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .mask_we_i (mask_we[n]),
            .wdata_i   (reg_wdata_i),
            .pend_i    (pend_q),
            .mask_o    (mask_q[n]),
            .status_o  (status_w[n]),
            .irq_o     (cpu_irq_o[n])
        );
    end

    irq_rd_mux #(
        .N_CPUS  (N_CPUS),
        .N_LINES (N_LINES),
        .CPU_W   (CPU_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (reg_rd_i),
        .bank_i    (bank),
        .cpu_sel_i (cpu_sel),
        .mask_i    (mask_q),
        .status_i  (status_w),
        .rdata_o   (reg_rdata_o)
    );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
    parameter int N_CPUS  = 4,
    parameter int N_LINES = 64,
    parameter int CPU_W   = 2,
    parameter int ADDR_W  = 9
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_LINES-1:0]             dev_irq,
    input logic                           reg_wr,
    input logic                           reg_rd,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic [N_LINES-1:0]             reg_wdata,
    input logic [N_LINES-1:0]             reg_rdata,
    input logic [N_CPUS-1:0]              cpu_irq,
    input logic [N_LINES-1:0]             pend,
    input logic [N_CPUS-1:0][N_LINES-1:0] masks
);
    logic             bank_bit;
    logic [CPU_W-1:0] cpu_field;
    assign bank_bit  = reg_addr[ADDR_W-1];
    assign cpu_field = reg_addr[6 +: CPU_W];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0 && reg_rdata == '0 && pend == '0));

    assert_pend_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(dev_irq));

    assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && bank_bit) |=> $stable(masks));

    for (genvar n = 0; n < N_CPUS; n++) begin : g_chk
        localparam logic [CPU_W-1:0] CN = CPU_W'(n);

        assert_irq_is_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> cpu_irq[n] == |($past(masks[n]) & $past(pend)));

        assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !bank_bit && cpu_field == CN) |=> masks[n] == $past(reg_wdata));

        assert_status_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && bank_bit && cpu_field == CN)
                |=> reg_rdata == ($past(masks[n]) & $past(pend)));

        assert_mask_read_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && !bank_bit && cpu_field == CN) |=> reg_rdata == $past(masks[n]));
    end
endmodule

bind irq_router irq_router_chk #(
    .N_CPUS  (N_CPUS),
    .N_LINES (N_LINES),
    .CPU_W   (CPU_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq_i),
    .reg_wr    (reg_wr_i),
    .reg_rd    (reg_rd_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .reg_rdata (reg_rdata_o),
    .cpu_irq   (cpu_irq_o),
    .pend      (pend_q),
    .masks     (mask_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    localparam int NC = 4;
    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] dev_irq = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [8:0]    reg_addr = '0;
    logic [NL-1:0] reg_wdata = '0;
    logic [NL-1:0] reg_rdata;
    logic [NC-1:0] cpu_irq;

    int n_checks = 0;
    int n_err    = 0;
    logic [NL-1:0] m_mask [NC];
    logic [NL-1:0] m_dev;

    always #10 clk = ~clk;

    irq_router uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_irq_i   (dev_irq),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .cpu_irq_o   (cpu_irq)
    );

    function automatic logic [8:0] adr(input int bank, input int cpu, input int low);
        return {bank[0], cpu[1:0], low[5:0]};
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] v;
        for (int n = 0; n < NC; n++) v[n] = |(m_mask[n] & m_dev);
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [NL-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [NL-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_mask(input int n, input logic [NL-1:0] d);
        wr(adr(0, n, 0), d);
        m_mask[n] = d;
    endtask

    task automatic set_dev(input logic [NL-1:0] d);
        dev_irq = d; m_dev = d;
        tick();
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, NL'(cpu_irq), NL'(exp_irq()));
    endtask

    task automatic chk_all_status(input string tag);
        logic [NL-1:0] v;
        for (int n = 0; n < NC; n++) begin
            rd(adr(1, n, 0), v);
            chk(tag, v, m_mask[n] & m_dev);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [NL-1:0] v;
        m_dev = '0;
        for (int n = 0; n < NC; n++) m_mask[n] = '0;
        dev_irq = '1;
        repeat (3) tick();
        // R1: outputs quiet while held in reset even with lines high
        chk("R1 irq in reset", NL'(cpu_irq), '0);
        chk("R1 rdata in reset", reg_rdata, '0);
        dev_irq = '0;
        rst_n = 1'b1;
        tick();
        for (int b = 0; b < 2; b++)
            for (int n = 0; n < NC; n++) begin
                rd(adr(b, n, 0), v);
                chk("R1 register zero after reset", v, '0);
            end

        // R6: mask write/readback, stray low address bits
        set_mask(0, '1);
        wr(adr(0, 1, 6'h2A), 64'h5555_5555_5555_5555);
        m_mask[1] = 64'h5555_5555_5555_5555;
        set_mask(2, 64'hFFFF_FFFF_0000_0000);
        set_mask(3, 64'h8000_0000_0000_0001);
        for (int n = 0; n < NC; n++) begin
            rd(adr(0, n, 6'h3F), v);
            chk("R6 mask readback", v, m_mask[n]);
        end

        // R2 R3 R4: walk one pending bit over every line
        for (int b = 0; b < NL; b++) begin
            set_dev(NL'(1) << b);
            chk_all_status("R3 status single-hot");
            chk_irq("R4 irq single-hot");
        end
        // R2: line falls clears pending
        set_dev('0);
        chk_all_status("R2 pending cleared");
        tick();
        chk_irq("R2 irq after clear");

        // R3: multi-bit patterns
        set_dev(64'hA5A5_0F0F_3C3C_8001);
        chk_all_status("R3 pattern a");
        chk_irq("R4 pattern a");
        set_dev(64'h7FFF_FFFE_0000_0000);
        chk_all_status("R3 pattern b");
        chk_irq("R4 pattern b");

        // R4: mask newly enables pending bit
        set_mask(3, '0);
        tick();
        chk_irq("R4 cpu3 masked off");
        set_dev(64'h0000_0000_0000_0110);
        tick();
        set_mask(3, 64'h0000_0000_0000_0100);
        chk("R4 irq not yet", NL'(cpu_irq[3]), '0);
        tick();
        chk("R4 enable pending raises irq", NL'(cpu_irq[3]), NL'(1));

        // R5: remove one of two contributors, then the last
        set_mask(3, 64'h0000_0000_0000_0110);
        tick();
        set_mask(3, 64'h0000_0000_0000_0010);
        tick();
        chk("R5 irq stays with other bit", NL'(cpu_irq[3]), NL'(1));
        set_mask(3, 64'h0000_0000_0000_0100);
        tick();
        chk("R5 irq stays after swap", NL'(cpu_irq[3]), NL'(1));
        set_mask(3, 64'h0000_0000_0000_1000);
        tick();
        chk("R5 removal withdraws irq", NL'(cpu_irq[3]), '0);
        chk_all_status("R5 status after removal");

        // R7: status bank writes ignored
        for (int n = 0; n < NC; n++) begin
            wr(adr(1, n, 0), 64'hDEAD_BEEF_CAFE_F00D);
            rd(adr(0, n, 0), v);
            chk("R7 mask unchanged", v, m_mask[n]);
        end
        chk_all_status("R7 status unchanged");
        tick();
        chk_irq("R7 irq unchanged");

        // R8: collision read/write returns old, then holds, then new
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = adr(0, 2, 0);
        reg_wdata = 64'h0123_4567_89AB_CDEF;
        tick();
        reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R8 collision returns old", reg_rdata, m_mask[2]);
        m_mask[2] = 64'h0123_4567_89AB_CDEF;
        tick();
        chk("R8 rdata held", reg_rdata, 64'hFFFF_FFFF_0000_0000);
        rd(adr(0, 2, 0), v);
        chk("R8 new value visible", v, m_mask[2]);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule